// File: doc/BRIEF.md
# Four-Level Address Translation Walker

This block turns a 64-bit virtual address into a 40-bit physical address by reading one entry from each of four nested tables in memory. The first table's base comes from a root pointer input; each entry read supplies the base of the next table, and the last one supplies the 4 KB frame. On each walk the block checks the request's access kind against the permission bits of every entry it passes through. It then returns a physical address or a fault code, together with the level at which the walk stopped.

A client presents a request with `req_valid` while `busy` is low. The block runs one walk at a time over a single-outstanding memory port. It issues 8-byte reads. Where an entry's accessed bit is clear, or the final entry's dirty bit must be set, it writes the updated entry back before moving on. The result is shown for exactly one cycle on `res_valid`.

Top module: `pt_walker`

## Requirements
- R1: A request whose bits 63:47 are not all equal finishes with fault code 1 and level 3 and makes no memory access. An address with all of them set is walked normally.
- R2: Four entries are read in this order: the index from VA bits 47:39 in the root table (level 3), then bits 38:30 (level 2), bits 29:21 (level 1) and bits 20:12 (level 0). Each entry address is the table base (entry bits 39:12, or root_ptr bits 39:12) times 4096 plus index times 8. On success the result is entry bits 39:12 of the level-0 entry, followed by VA bits 11:0.
- R3: An entry with bit 0 (present) clear ends the walk with fault code 2 and the current level.
- R4: A write (req_acc = 1) that passes through any entry with bit 1 (writable) clear ends with fault code 3.
- R5: A user request (req_user = 1) that passes through any entry with bit 2 (user) clear ends with fault code 4.
- R6: A fetch (req_acc = 2) with nxe_en set that passes through any entry with bit 63 set ends with fault code 5. Reads are not affected by bit 63, and neither are fetches while nxe_en is clear.
- R7: Every entry that passes its checks and has bit 5 (accessed) clear is written back once with bit 5 set. An entry that already has bit 5 set is not written.
- R8: A successful write sets bit 6 (dirty) in the level-0 entry. Bits 5 and 6 go out in a single write-back.
- R9: `busy` is high from acceptance until the result cycle. A request presented while `busy` is high is ignored. `res_valid` lasts one cycle per accepted request.
- R10: Within one entry, the checks run in this order: present, then writable, then user, then execute-disable. The first one that fails sets the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| root_ptr | input | 64 | Root table base in bits 39:12 |
| nxe_en | input | 1 | Enables the execute-disable check |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 64 | Virtual address |
| req_acc | input | 2 | 0 read, 1 write, 2 fetch |
| req_user | input | 1 | 1 for a user access |
| busy | output | 1 | Walk in progress |
| res_valid | output | 1 | Result present this cycle |
| res_fault | output | 3 | 0 ok, 1 non-canonical, 2 not present, 3 write, 4 user, 5 execute |
| res_level | output | 2 | Level at which the walk stopped (3 root, 0 last) |
| res_paddr | output | 40 | Physical address (zero on fault) |
| mem_req_valid | output | 1 | Memory request, one cycle |
| mem_req_we | output | 1 | 1 for an entry write-back |
| mem_req_addr | output | 40 | Entry byte address |
| mem_req_wdata | output | 64 | Write-back data |
| mem_rsp_valid | input | 1 | Memory response or write acknowledge |
| mem_rsp_rdata | input | 64 | Entry read data |

## Verification
The walk runs against one fixed tree of tables. The tree mixes fully permissive entries, read-only entries, supervisor-only entries, absent entries and execute-disabled entries at both the directory level and the last level. Each access kind and privilege is tried against each of these entries, so every fault code is produced at more than one level. Pairs such as write-by-user through a read-only supervisor entry show the check order. The same execute-disabled page under read, under fetch with the check on, and under fetch with it off separates the three cases. Memory is inspected after the walks to count write-backs and to read the accessed and dirty bits. Repeated walks over entries that are already marked must cause no writes. Addresses with the sign bits broken in either direction must cause no memory access at all.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int PA_W = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [63:0]     root_ptr,
  input  logic            nxe_en,
  input  logic            req_valid,
  input  logic [63:0]     req_vaddr,
  input  logic [1:0]      req_acc,
  input  logic            req_user,
  output logic            busy,
  output logic            res_valid,
  output logic [2:0]      res_fault,
  output logic [1:0]      res_level,
  output logic [PA_W-1:0] res_paddr,
  output logic            mem_req_valid,
  output logic            mem_req_we,
  output logic [PA_W-1:0] mem_req_addr,
  output logic [63:0]     mem_req_wdata,
  input  logic            mem_rsp_valid,
  input  logic [63:0]     mem_rsp_rdata
);
  localparam int BW = PA_W - 12;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_RWAIT, S_WR, S_WWAIT, S_FIN} st_t;
  st_t st;

  logic [63:0]   va, ent, wdat;
  logic [1:0]    acc, lvl;
  logic          usr, nx;
  logic [BW-1:0] base;
  logic [8:0]    idx;
  logic [2:0]    chk;
  logic [63:0]   upd;
  logic [63:0]   nsrc;
  logic          advance;

  always_comb begin
    case (lvl)
      2'd3:    idx = va[47:39];
      2'd2:    idx = va[38:30];
      2'd1:    idx = va[29:21];
      default: idx = va[20:12];
    endcase
  end

  wire canon = (&req_vaddr[63:47]) | ~(|req_vaddr[63:47]);
  wire is_wr = (acc == 2'd1);
  wire is_fx = (acc == 2'd2);

  assign busy          = (st != S_IDLE);
  assign res_valid     = (st == S_FIN);
  assign mem_req_valid = (st == S_RD) || (st == S_WR);
  assign mem_req_we    = (st == S_WR);
  assign mem_req_addr  = {base, idx, 3'b000};
  assign mem_req_wdata = wdat;

  always_comb begin
    if (!mem_rsp_rdata[0])                        chk = 3'd2;
    else if (is_wr && !mem_rsp_rdata[1])          chk = 3'd3;
    else if (usr && !mem_rsp_rdata[2])            chk = 3'd4;
    else if (is_fx && nx && mem_rsp_rdata[63])    chk = 3'd5;
    else                                          chk = 3'd0;
  end

  assign upd = mem_rsp_rdata | 64'h20 | ((lvl == 2'd0 && is_wr) ? 64'h40 : 64'h0);

  assign nsrc    = (st == S_WWAIT) ? ent : mem_rsp_rdata;
  assign advance = mem_rsp_valid &&
                   ((st == S_WWAIT) || (st == S_RWAIT && chk == 3'd0 && upd == mem_rsp_rdata));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      va        <= '0;
      ent       <= '0;
      wdat      <= '0;
      acc       <= '0;
      lvl       <= '0;
      usr       <= 1'b0;
      nx        <= 1'b0;
      base      <= '0;
      res_fault <= '0;
      res_level <= '0;
      res_paddr <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va   <= req_vaddr;
          acc  <= req_acc;
          usr  <= req_user;
          nx   <= nxe_en;
          base <= root_ptr[PA_W-1:12];
          lvl  <= 2'd3;
          if (!canon) begin
            res_fault <= 3'd1;
            res_level <= 2'd3;
            res_paddr <= '0;
            st        <= S_FIN;
          end else begin
            st <= S_RD;
          end
        end
        S_RD: st <= S_RWAIT;
        S_RWAIT: if (mem_rsp_valid) begin
          ent <= mem_rsp_rdata;
          if (chk != 3'd0) begin
            res_fault <= chk;
            res_level <= lvl;
            res_paddr <= '0;
            st        <= S_FIN;
          end else if (upd != mem_rsp_rdata) begin
            wdat <= upd;
            st   <= S_WR;
          end
        end
        S_WR: st <= S_WWAIT;
        S_FIN: st <= S_IDLE;
        default: ;
      endcase
      if (advance) begin
        if (lvl == 2'd0) begin
          res_fault <= 3'd0;
          res_level <= 2'd0;
          res_paddr <= {nsrc[PA_W-1:12], va[11:0]};
          st        <= S_FIN;
        end else begin
          base <= nsrc[PA_W-1:12];
          lvl  <= lvl - 2'd1;
          st   <= S_RD;
        end
      end
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PA_W = 40
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [63:0]     req_vaddr,
  input logic            busy,
  input logic            res_valid,
  input logic [2:0]      res_fault,
  input logic            mem_req_valid,
  input logic            mem_req_we,
  input logic [PA_W-1:0] mem_req_addr,
  input logic [63:0]     mem_req_wdata
);
  // R1
  noncanon_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !((&req_vaddr[63:47]) || !(|req_vaddr[63:47])))
      |=> (res_valid && res_fault == 3'd1 && !mem_req_valid));

  // R2
  entry_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

  // R7
  wb_accessed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we) |-> mem_req_wdata[5]);

  // R9
  mem_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);

  // R9
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);

  // R10
  fault_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_fault <= 3'd5));
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .busy(busy), .res_valid(res_valid), .res_fault(res_fault),
  .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
  .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata)
);

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] root_ptr = 64'h1000;
  logic        nxe_en = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        req_user = 1'b0;
  logic        busy, res_valid;
  logic [2:0]  res_fault;
  logic [1:0]  res_level;
  logic [39:0] res_paddr;
  logic        mem_req_valid, mem_req_we;
  logic [39:0] mem_req_addr;
  logic [63:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_rdata = '0;

  always #2 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .root_ptr(root_ptr), .nxe_en(nxe_en),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_acc(req_acc), .req_user(req_user),
    .busy(busy), .res_valid(res_valid), .res_fault(res_fault), .res_level(res_level),
    .res_paddr(res_paddr), .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  logic [63:0] mem [logic [39:0]];
  int n_rd, n_wr, n_res, tests, fails;
  logic [39:0] rd_log [4];
  logic        pend = 1'b0;
  logic [63:0] pdat = '0;

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (pend) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_rdata <= pdat;
      pend          <= 1'b0;
    end
    if (mem_req_valid) begin
      pend <= 1'b1;
      if (mem_req_we) begin
        mem[mem_req_addr] = mem_req_wdata;
        n_wr++;
        pdat <= '0;
      end else begin
        if (n_rd < 4) rd_log[n_rd] = mem_req_addr;
        n_rd++;
        pdat <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'h0;
      end
    end
    if (res_valid) n_res++;
  end

  task automatic init_mem();
    mem.delete();
    mem[40'h1008] = 64'h2007;
    mem[40'h2010] = 64'h3007;
    mem[40'h3018] = 64'h4007;
    mem[40'h3028] = 64'h4005;
    mem[40'h3030] = 64'h4003;
    mem[40'h4000] = 64'hABCDE007;
    mem[40'h4008] = 64'h11111001;
    mem[40'h4018] = 64'h8000_0000_3333_3007;
    mem[40'h4020] = 64'h44444067;
  endtask

  task automatic chk(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  logic [2:0]  g_f;
  logic [1:0]  g_l;
  logic [39:0] g_pa;

  task automatic run(input logic [63:0] va, input logic [1:0] acc, input logic u, input logic nx);
    int t;
    n_rd = 0; n_wr = 0;
    @(negedge clk);
    req_vaddr = va; req_acc = acc; req_user = u; nxe_en = nx; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!res_valid && t < 2000) begin @(negedge clk); t++; end
    if (!res_valid) chk("R9", "walk timeout", 64'h0, 64'h1);
    g_f = res_fault; g_l = res_level; g_pa = res_paddr;
    @(negedge clk);
  endtask

  function automatic logic [63:0] mkva(input logic [8:0] pd, input logic [8:0] pt);
    return {16'h0, 9'd1, 9'd2, pd, pt, 12'h123};
  endfunction

  function automatic string tag_of(input logic [2:0] f);
    case (f)
      3'd0: return "R2";
      3'd1: return "R1";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  typedef struct packed {
    logic [8:0]  pd;
    logic [8:0]  pt;
    logic [1:0]  acc;
    logic        usr;
    logic        nx;
    logic [2:0]  f;
    logic [1:0]  lv;
    logic [39:0] pa;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{9'd3, 9'd0, 2'd0, 1'b1, 1'b0, 3'd0, 2'd0, 40'hABCDE123}, // R2 read
    '{9'd3, 9'd0, 2'd1, 1'b1, 1'b1, 3'd0, 2'd0, 40'hABCDE123}, // R8 write ok
    '{9'd3, 9'd0, 2'd2, 1'b1, 1'b1, 3'd0, 2'd0, 40'hABCDE123}, // R6 fetch ok
    '{9'd3, 9'd1, 2'd1, 1'b0, 1'b0, 3'd3, 2'd0, 40'h0},        // R4 leaf
    '{9'd3, 9'd1, 2'd0, 1'b1, 1'b0, 3'd4, 2'd0, 40'h0},        // R5 leaf
    '{9'd3, 9'd1, 2'd0, 1'b0, 1'b0, 3'd0, 2'd0, 40'h11111123}, // R2
    '{9'd3, 9'd2, 2'd0, 1'b0, 1'b0, 3'd2, 2'd0, 40'h0},        // R3 leaf
    '{9'd4, 9'd0, 2'd0, 1'b0, 1'b0, 3'd2, 2'd1, 40'h0},        // R3 directory
    '{9'd5, 9'd0, 2'd1, 1'b0, 1'b0, 3'd3, 2'd1, 40'h0},        // R4 directory
    '{9'd6, 9'd0, 2'd0, 1'b1, 1'b0, 3'd4, 2'd1, 40'h0},        // R5 directory
    '{9'd3, 9'd3, 2'd2, 1'b0, 1'b1, 3'd5, 2'd0, 40'h0},        // R6 blocked
    '{9'd3, 9'd3, 2'd2, 1'b0, 1'b0, 3'd0, 2'd0, 40'h33333123}, // R6 check off
    '{9'd3, 9'd3, 2'd0, 1'b0, 1'b1, 3'd0, 2'd0, 40'h33333123}, // R6 read
    '{9'd3, 9'd1, 2'd1, 1'b1, 1'b0, 3'd3, 2'd0, 40'h0},        // R10 write before user
    '{9'd4, 9'd0, 2'd1, 1'b1, 1'b1, 3'd2, 2'd1, 40'h0},        // R10 present first
    '{9'd3, 9'd4, 2'd1, 1'b1, 1'b0, 3'd0, 2'd0, 40'h44444123}  // R8 already dirty
  };

  bit finished = 1'b0;

  initial begin
    #800000;
    if (!finished) begin
      tests++; fails++;
      $display("FAIL R9 watchdog actual=%h expected=%h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tests = 0; fails = 0; n_rd = 0; n_wr = 0; n_res = 0;
    init_mem();
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "reset busy", {63'h0, busy}, 64'h0);
    chk("R9", "reset res_valid", {63'h0, res_valid}, 64'h0);
    chk("R9", "reset mem_req", {63'h0, mem_req_valid}, 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      init_mem();
      run(mkva(VECS[i].pd, VECS[i].pt), VECS[i].acc, VECS[i].usr, VECS[i].nx);
      chk(tag_of(VECS[i].f), $sformatf("vec %0d fault", i), {61'h0, g_f}, {61'h0, VECS[i].f});
      chk(tag_of(VECS[i].f), $sformatf("vec %0d level", i), {62'h0, g_l}, {62'h0, VECS[i].lv});
      chk(tag_of(VECS[i].f), $sformatf("vec %0d paddr", i), {24'h0, g_pa}, {24'h0, VECS[i].pa});
    end

    // R1 non-canonical, both directions
    init_mem();
    run(64'h0000_8000_0000_0000, 2'd0, 1'b0, 1'b0);
    chk("R1", "bit47 set fault", {61'h0, g_f}, 64'd1);
    chk("R1", "bit47 set level", {62'h0, g_l}, 64'd3);
    chk("R1", "bit47 set mem reads", n_rd, 0);
    run(64'hFFFF_0000_0000_1000, 2'd1, 1'b1, 1'b0);
    chk("R1", "upper set fault", {61'h0, g_f}, 64'd1);
    chk("R1", "upper set mem reads", n_rd + n_wr, 0);
    // R1 canonical high half is walked: root index 256 absent
    run(64'hFFFF_8000_0000_1000, 2'd0, 1'b0, 1'b0);
    chk("R1", "high canonical fault", {61'h0, g_f}, 64'd2);
    chk("R3", "high canonical level", {62'h0, g_l}, 64'd3);
    chk("R1", "high canonical reads", n_rd, 1);

    // R2 read address order, R7 accessed write-back
    init_mem();
    run(mkva(9'd3, 9'd0), 2'd0, 1'b0, 1'b0);
    chk("R2", "read addr 0", {24'h0, rd_log[0]}, 64'h1008);
    chk("R2", "read addr 1", {24'h0, rd_log[1]}, 64'h2010);
    chk("R2", "read addr 2", {24'h0, rd_log[2]}, 64'h3018);
    chk("R2", "read addr 3", {24'h0, rd_log[3]}, 64'h4000);
    chk("R7", "writes on first read walk", n_wr, 4);
    chk("R7", "root entry", mem[40'h1008], 64'h2027);
    chk("R7", "level2 entry", mem[40'h2010], 64'h3027);
    chk("R7", "level1 entry", mem[40'h3018], 64'h4027);
    chk("R7", "leaf entry not dirty", mem[40'h4000], 64'hABCDE027);
    // R8 write after A set: one write-back with dirty
    run(mkva(9'd3, 9'd0), 2'd1, 1'b0, 1'b0);
    chk("R8", "writes on marked write walk", n_wr, 1);
    chk("R8", "leaf dirty", mem[40'h4000], 64'hABCDE067);
    // R7 nothing written when already marked
    run(mkva(9'd3, 9'd0), 2'd1, 1'b0, 1'b0);
    chk("R7", "writes when all marked", n_wr, 0);

    // R8 fresh write walk: A and D in one write per entry
    init_mem();
    run(mkva(9'd3, 9'd0), 2'd1, 1'b1, 1'b0);
    chk("R8", "writes fresh write walk", n_wr, 4);
    chk("R8", "leaf A and D", mem[40'h4000], 64'hABCDE067);

    // R7 faulting entry is not marked
    init_mem();
    run(mkva(9'd5, 9'd0), 2'd1, 1'b0, 1'b0);
    chk("R7", "faulting dir entry untouched", mem[40'h3028], 64'h4005);

    // R9 request while busy ignored
    init_mem();
    n_res = 0;
    @(negedge clk);
    req_vaddr = mkva(9'd3, 9'd0); req_acc = 2'd0; req_user = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9", "busy after accept", {63'h0, busy}, 64'h1);
    repeat (2) @(negedge clk);
    req_vaddr = 64'h0000_8000_0000_0000; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    begin
      int t = 0;
      while (!res_valid && t < 2000) begin @(negedge clk); t++; end
    end
    chk("R9", "first result kept fault", {61'h0, res_fault}, 64'd0);
    chk("R9", "first result kept paddr", {24'h0, res_paddr}, 64'hABCDE123);
    repeat (20) @(negedge clk);
    chk("R9", "single result pulse", n_res, 1);
    chk("R9", "idle after result", {63'h0, busy}, 64'h0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule